// File: doc/BRIEF.md
# 8032 Operand Address Resolver

This block turns a decoded addressing-mode code and the raw instruction bytes of an 8032-class core into a single operand access request. From the opcode, the two bytes that follow it, the active register-bank bits and the 16-bit data pointer, it works out which space the operand lives in. The spaces are internal RAM, the special-function-register space, external data memory and an immediate constant. It also gives the 16-bit address or constant value and whether the access is 8 or 16 bits wide.

Register-indirect operands need the contents of R0 or R1 of the active bank. The block reads that register through an internal-RAM read port, which has a one-cycle synchronous latency, and issues the request one cycle later than the other modes. External access through an 8-bit register pointer is rejected: it raises an illegal-mode pulse and issues no request. The same happens for the reserved mode code. While a pointer read is in flight, a new request strobe is ignored.

Mode codes on `mode`: 000 register, 001 direct, 010 register-indirect, 011 8-bit immediate, 100 external via data pointer, 101 external via register pointer (illegal), 110 reserved (illegal), 111 16-bit immediate. Bit 2 with bits 1:0 = 11 selects the immediate width.

Top module: `opaddr_resolver`

## Requirements
- R1: Register mode (000) produces space 00 (RAM) at address {bank, opc[2:0]}, width flag 0, with `acc_vld` high in the cycle after the request edge.
- R2: Direct mode (001) with `byte1` in 00h–7Fh produces space 00 (RAM) at address `byte1`, width 0, one cycle after the request.
- R3: Direct mode (001) with `byte1` in 80h–FFh produces space 01 (SFR) at address `byte1`, width 0, one cycle after the request.
- R4: Register-indirect mode (010) drives `ram_rd` high and `ram_raddr` = {bank, 00, opc[0]} in the request cycle. It produces space 00 (RAM) at the pointer value read back, including values 80h and above. `acc_vld` stays low one cycle after the request and goes high two cycles after it.
- R5: 8-bit immediate mode (011) produces space 11 with address {00h, byte1} and width 0, one cycle after the request.
- R6: 16-bit immediate mode (111) produces space 11 with address {byte1, byte2} (byte1 is the high byte) and width 1, one cycle after the request.
- R7: External data-pointer mode (100) produces space 10 (XDATA) at address `dptr`, width 1, one cycle after the request.
- R8: Modes 101 and 110 pulse `bad_mode` for one cycle, one cycle after the request. They keep `acc_vld` low and do not assert `ram_rd`. `acc_vld` and `bad_mode` are never high together.
- R9: `acc_vld` is a one-cycle pulse per accepted request. A request strobe in the cycle after an indirect request is accepted is ignored.
- R10: While `rst_n` is low, `acc_vld` and `bad_mode` are low and requests have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Resolve request strobe |
| mode | input | 3 | Addressing-mode code |
| opc | input | 8 | Opcode byte |
| byte1 | input | 8 | First byte after the opcode |
| byte2 | input | 8 | Second byte after the opcode |
| bank | input | 2 | Active register-bank select |
| dptr | input | 16 | Data pointer value |
| ram_rd | output | 1 | Internal-RAM pointer read enable |
| ram_raddr | output | 8 | Internal-RAM pointer read address |
| ram_rdata | input | 8 | Internal-RAM read data, one cycle after `ram_rd` |
| acc_vld | output | 1 | Access request valid pulse |
| acc_space | output | 2 | Target space: 00 RAM, 01 SFR, 10 XDATA, 11 immediate |
| acc_addr | output | 16 | Address or immediate value |
| acc_wide | output | 1 | 1 for a 16-bit access or value |
| bad_mode | output | 1 | Illegal-mode pulse |

## Verification
Every mode except register-indirect answers one edge after the request edge, so the bench drives a request at a falling edge and samples the result at the next falling edge. Register-indirect results come one edge later. The bench first confirms that `acc_vld` is still low at the intermediate falling edge, then samples the result. The read-port address and enable are combinational, so they are checked in the request cycle itself, shortly after the inputs settle. One further falling edge is sampled after each result to confirm the valid and illegal strobes have dropped.

// File: rtl/opr_pkg.sv
package opr_pkg;
  typedef enum logic [2:0] {
    AM_REG   = 3'b000,
    AM_DIR   = 3'b001,
    AM_IND   = 3'b010,
    AM_IMM8  = 3'b011,
    AM_XDIR  = 3'b100,
    AM_XIND  = 3'b101,
    AM_RSVD  = 3'b110,
    AM_IMM16 = 3'b111
  } amode_e;

  typedef enum logic [1:0] {
    SP_RAM   = 2'b00,
    SP_SFR   = 2'b01,
    SP_XDATA = 2'b10,
    SP_IMM   = 2'b11
  } space_e;
endpackage

// File: rtl/opr_decode.sv
module opr_decode
  import opr_pkg::*;
#(
  parameter int DW     = 8,
  parameter int AW     = 16,
  parameter int BANK_W = 2,
  parameter int REG_W  = 3
) (
  input  amode_e            mode,
  input  logic [DW-1:0]     opc,
  input  logic [DW-1:0]     byte1,
  input  logic [DW-1:0]     byte2,
  input  logic [BANK_W-1:0] bank,
  input  logic [AW-1:0]     dptr,
  output space_e            space,
  output logic [AW-1:0]     addr,
  output logic              wide,
  output logic              legal,
  output logic              needs_ptr,
  output logic [DW-1:0]     ptr_raddr
);
  localparam int PAD_W = AW - DW;

  // Pointer register R0/R1 of the active bank
  assign ptr_raddr = {bank, {(REG_W-1){1'b0}}, opc[0]};

  always_comb begin
    space     = SP_RAM;
    addr      = '0;
    wide      = 1'b0;
    legal     = 1'b1;
    needs_ptr = 1'b0;
    unique case (mode)
      AM_REG:   addr = {{PAD_W{1'b0}}, bank, opc[REG_W-1:0]};
      AM_DIR: begin
        space = byte1[DW-1] ? SP_SFR : SP_RAM;
        addr  = {{PAD_W{1'b0}}, byte1};
      end
      AM_IND:   needs_ptr = 1'b1;
      AM_IMM8: begin
        space = SP_IMM;
        addr  = {{PAD_W{1'b0}}, byte1};
      end
      AM_IMM16: begin
        space = SP_IMM;
        addr  = {byte1, byte2};
        wide  = 1'b1;
      end
      AM_XDIR: begin
        space = SP_XDATA;
        addr  = dptr;
        wide  = 1'b1;
      end
      AM_XIND, AM_RSVD: legal = 1'b0;
      default:          legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/opr_ptr_fetch.sv
module opr_ptr_fetch (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic pend
);
  logic pend_nxt;

  always_comb pend_nxt = start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= pend_nxt;
  end

  p_start_pends_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> pend);
  p_single_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pend |=> !pend);
endmodule

// File: rtl/opaddr_resolver.sv
module opaddr_resolver
  import opr_pkg::*;
#(
  parameter int DW     = 8,
  parameter int AW     = 16,
  parameter int BANK_W = 2,
  parameter int REG_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld,
  input  logic [2:0]        mode,
  input  logic [DW-1:0]     opc,
  input  logic [DW-1:0]     byte1,
  input  logic [DW-1:0]     byte2,
  input  logic [BANK_W-1:0] bank,
  input  logic [AW-1:0]     dptr,
  output logic              ram_rd,
  output logic [DW-1:0]     ram_raddr,
  input  logic [DW-1:0]     ram_rdata,
  output logic              acc_vld,
  output logic [1:0]        acc_space,
  output logic [AW-1:0]     acc_addr,
  output logic              acc_wide,
  output logic              bad_mode
);
  localparam int PAD_W = AW - DW;

  amode_e        mode_e;
  space_e        dec_space;
  logic [AW-1:0] dec_addr;
  logic          dec_wide, dec_legal, dec_ptr;
  logic          pend, accept;

  space_e        space_q, space_nxt;
  logic [AW-1:0] addr_nxt;
  logic          wide_nxt, vld_nxt, bad_nxt, load_en;

  assign mode_e = amode_e'(mode);
  assign accept = req_vld && !pend;
  assign ram_rd = accept && dec_ptr;

  opr_decode #(.DW(DW), .AW(AW), .BANK_W(BANK_W), .REG_W(REG_W)) u_dec (
    .mode(mode_e), .opc(opc), .byte1(byte1), .byte2(byte2), .bank(bank),
    .dptr(dptr), .space(dec_space), .addr(dec_addr), .wide(dec_wide),
    .legal(dec_legal), .needs_ptr(dec_ptr), .ptr_raddr(ram_raddr)
  );

  opr_ptr_fetch u_fetch (.clk(clk), .rst_n(rst_n), .start(ram_rd), .pend(pend));

  // Next-state
  always_comb begin
    space_nxt = dec_space;
    addr_nxt  = dec_addr;
    wide_nxt  = dec_wide;
    vld_nxt   = accept && dec_legal && !dec_ptr;
    bad_nxt   = accept && !dec_legal;
    if (pend) begin
      space_nxt = SP_RAM;
      addr_nxt  = {{PAD_W{1'b0}}, ram_rdata};
      wide_nxt  = 1'b0;
      vld_nxt   = 1'b1;
    end
    load_en = vld_nxt;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_vld  <= 1'b0;
      bad_mode <= 1'b0;
    end else begin
      acc_vld  <= vld_nxt;
      bad_mode <= bad_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      space_q  <= SP_RAM;
      acc_addr <= '0;
      acc_wide <= 1'b0;
    end else if (load_en) begin
      space_q  <= space_nxt;
      acc_addr <= addr_nxt;
      acc_wide <= wide_nxt;
    end
  end

  assign acc_space = space_q;

  p_vld_bad_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_vld && bad_mode));
  p_illegal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (mode_e == AM_XIND || mode_e == AM_RSVD)) |=> (bad_mode && !acc_vld));
  p_no_read_illegal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_e == AM_XIND || mode_e == AM_RSVD) |-> !ram_rd);
  p_direct_space_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mode_e == AM_DIR) |=>
      (acc_vld && acc_space == ($past(byte1[DW-1]) ? SP_SFR : SP_RAM)));
  p_ptr_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pend |=> (acc_vld && acc_space == SP_RAM && !acc_wide));
  p_ptr_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ram_rd |=> !acc_vld);
endmodule

// File: tb/opaddr_resolver_bench.sv
module opaddr_resolver_bench;
  typedef struct packed {
    logic [2:0]  mode;
    logic [7:0]  opc;
    logic [7:0]  b1;
    logic [7:0]  b2;
    logic [1:0]  bank;
    logic [15:0] dptr;
    logic [1:0]  e_space;
    logic [15:0] e_addr;
    logic        e_wide;
    logic        e_bad;
    logic [7:0]  e_raddr;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VT [NV] = '{
    '{3'b000, 8'hEF, 8'h00, 8'h00, 2'd2, 16'h0000, 2'd0, 16'h0017, 1'b0, 1'b0, 8'h00, 4'd1}, // R1
    '{3'b000, 8'hE8, 8'h00, 8'h00, 2'd0, 16'h0000, 2'd0, 16'h0000, 1'b0, 1'b0, 8'h00, 4'd1}, // R1
    '{3'b001, 8'hE5, 8'h40, 8'h00, 2'd1, 16'h0000, 2'd0, 16'h0040, 1'b0, 1'b0, 8'h00, 4'd2}, // R2
    '{3'b001, 8'hE5, 8'h7F, 8'h00, 2'd1, 16'h0000, 2'd0, 16'h007F, 1'b0, 1'b0, 8'h00, 4'd2}, // R2
    '{3'b001, 8'hE5, 8'h80, 8'h00, 2'd0, 16'h0000, 2'd1, 16'h0080, 1'b0, 1'b0, 8'h00, 4'd3}, // R3
    '{3'b001, 8'hE5, 8'hFF, 8'h00, 2'd0, 16'h0000, 2'd1, 16'h00FF, 1'b0, 1'b0, 8'h00, 4'd3}, // R3
    '{3'b010, 8'hE6, 8'h00, 8'h00, 2'd3, 16'h0000, 2'd0, 16'h00AB, 1'b0, 1'b0, 8'h18, 4'd4}, // R4
    '{3'b010, 8'hE7, 8'h00, 8'h00, 2'd0, 16'h0000, 2'd0, 16'h000A, 1'b0, 1'b0, 8'h01, 4'd4}, // R4
    '{3'b011, 8'h74, 8'h40, 8'h00, 2'd0, 16'h0000, 2'd3, 16'h0040, 1'b0, 1'b0, 8'h00, 4'd5}, // R5
    '{3'b111, 8'h90, 8'h12, 8'h34, 2'd0, 16'h0000, 2'd3, 16'h1234, 1'b1, 1'b0, 8'h00, 4'd6}, // R6
    '{3'b100, 8'hE0, 8'h00, 8'h00, 2'd1, 16'hBEEF, 2'd2, 16'hBEEF, 1'b1, 1'b0, 8'h00, 4'd7}, // R7
    '{3'b101, 8'hE2, 8'h00, 8'h00, 2'd0, 16'h0000, 2'd0, 16'h0000, 1'b0, 1'b1, 8'h00, 4'd8}, // R8
    '{3'b110, 8'h00, 8'h00, 8'h00, 2'd0, 16'h0000, 2'd0, 16'h0000, 1'b0, 1'b1, 8'h00, 4'd8}  // R8
  };

  logic        clk, rst_n, req_vld;
  logic [2:0]  mode;
  logic [7:0]  opc, byte1, byte2, ram_raddr, ram_rdata;
  logic [1:0]  bank, acc_space;
  logic [15:0] dptr, acc_addr;
  logic        ram_rd, acc_vld, acc_wide, bad_mode;
  int          n_chk, n_fail;
  bit          done;

  opaddr_resolver u_opaddr_resolver (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .mode(mode), .opc(opc),
    .byte1(byte1), .byte2(byte2), .bank(bank), .dptr(dptr), .ram_rd(ram_rd),
    .ram_raddr(ram_raddr), .ram_rdata(ram_rdata), .acc_vld(acc_vld),
    .acc_space(acc_space), .acc_addr(acc_addr), .acc_wide(acc_wide),
    .bad_mode(bad_mode)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] mem_fn(logic [7:0] a);
    return a * 8'd7 + 8'd3;
  endfunction

  always_ff @(posedge clk) if (ram_rd) ram_rdata <= mem_fn(ram_raddr);

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    mode = v.mode; opc = v.opc; byte1 = v.b1; byte2 = v.b2;
    bank = v.bank; dptr = v.dptr;
  endtask

  task automatic check_result(input vec_t v, input string rq);
    check(acc_vld == !v.e_bad, rq, "acc_vld", acc_vld, !v.e_bad);
    check(bad_mode == v.e_bad, rq, "bad_mode", bad_mode, v.e_bad);
    if (!v.e_bad) begin
      check(acc_space == v.e_space, rq, "acc_space", acc_space, v.e_space);
      check(acc_addr == v.e_addr, rq, "acc_addr", acc_addr, v.e_addr);
      check(acc_wide == v.e_wide, rq, "acc_wide", acc_wide, v.e_wide);
    end
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 0;
    rst_n = 1'b0; req_vld = 1'b0;
    drive('0);
    repeat (3) @(negedge clk);
    // R10 reset state
    check(!acc_vld && !bad_mode, "R10", "outputs in reset", {acc_vld, bad_mode}, 0);
    req_vld = 1'b1; mode = 3'b101;
    @(negedge clk);
    check(!acc_vld && !bad_mode, "R10", "request during reset", {acc_vld, bad_mode}, 0);
    req_vld = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      string rq;
      vec_t  v;
      v  = VT[i];
      rq = $sformatf("R%0d", v.rq);
      drive(v);
      req_vld = 1'b1;
      #1;
      check(ram_rd == (v.mode == 3'b010), rq, "ram_rd in request cycle", ram_rd, v.mode == 3'b010);
      if (v.mode == 3'b010)
        check(ram_raddr == v.e_raddr, rq, "ram_raddr", ram_raddr, v.e_raddr);
      @(negedge clk);
      req_vld = 1'b0;
      if (v.mode == 3'b010) begin
        check(!acc_vld, rq, "acc_vld early", acc_vld, 0);
        @(negedge clk);
      end
      check_result(v, rq);
      @(negedge clk);
      check(!acc_vld && !bad_mode, "R9", "strobes dropped", {acc_vld, bad_mode}, 0);
    end

    // R9: request right after an indirect request is ignored
    drive(VT[6]); req_vld = 1'b1;
    @(negedge clk);
    drive(VT[4]);                       // direct SFR request while pointer read pending
    @(negedge clk);
    req_vld = 1'b0;
    check(acc_vld && acc_addr == 16'h00AB && acc_space == 2'd0, "R9", "pointer result kept",
          acc_addr, 16'h00AB);
    @(negedge clk);
    check(!acc_vld, "R9", "pending-cycle request ignored", acc_vld, 0);

    // R2/R3 back to back
    drive(VT[3]); req_vld = 1'b1;
    @(negedge clk);
    check_result(VT[3], "R2");
    drive(VT[5]);
    @(negedge clk);
    req_vld = 1'b0;
    check_result(VT[5], "R3");

    // R10: reset mid-operation
    drive(VT[7]); req_vld = 1'b1;
    @(negedge clk);
    req_vld = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    check(!acc_vld && !bad_mode, "R10", "reset clears pending", {acc_vld, bad_mode}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!acc_vld, "R10", "no late result", acc_vld, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule